// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shifter

This block is a processor-driven shift engine for a three-wire serial EEPROM link. The link has a serial clock, one bidirectional data line and a chip select. Firmware drives the chip select from an ordinary pin, and firmware also builds the EEPROM command frames. Each write to the control register starts one burst of zero to eight serial clocks. The serial clock runs at a fixed 500 kHz, derived from the system clock by a parameterised divider.

In a transmit burst, bits leave the top of the 8-bit data register, most significant first. In a receive burst, bits sampled from the data line are shifted into the bottom of the data register, so the received value ends up right-justified.

A busy flag covers the whole burst, and a one-cycle interrupt marks its end. Two options shape the end of a burst:
- The data line can be released to high impedance right after the last rising clock.
- When release is also selected, the end of busy can be held back until the EEPROM raises the data line to signal that its internal write has finished.

Top module: `uw_eeprom_shifter`

## Requirements
- R1: After reset the block is idle. Busy, the serial clock and the interrupt are all low, the data line is driven (output enable high), and both registers read 0.
- R2: Control register fields are: bit 7 wait-for-ready, bit 6 busy (read only), bit 5 release-after-burst, bit 4 receive direction, and bits 3:0 clock count. A write with bit 4 clear issues count rising clocks. Data leaves data register bit 7, most significant bit first. Data changes only while the clock is low, so it is stable at each rising edge and through each high phase.
- R3: A write with bit 4 set issues count rising clocks and samples the data line at each rising edge. The sampled bits land most significant first in data register bits count-1..0, and the remaining bits hold the old contents shifted up. The data line is not driven during a receive burst.
- R4: A count value of 9 to 15 acts as 8 and reads back as 8.
- R5: With bit 5 set and a non-zero count, the output enable drops at the final rising clock edge and stays low after the burst. With bit 5 clear in a transmit burst, the data line stays driven throughout.
- R6: A count of 0 issues no clocks. The output enable then becomes the inverse of bit 5 regardless of bit 4, so a write of 0x00 takes back the data line after a receive.
- R7: Busy is high from the control write until the burst ends. Each falling edge of busy comes with exactly one interrupt pulse of one cycle, and there is no interrupt at any other time.
- R8: With bits 7 and 5 both set, busy stays high after the last clock until a rising edge is seen on the data input. With bit 5 clear, bit 7 has no effect and busy falls without any data-line change.
- R9: Writes to either register while busy is high are ignored. The running burst keeps its count and direction, and the data register is not overwritten.
- R10: The serial clock idles low, and one full clock period is 2*(SYS_HZ/(2*SCK_HZ)) system cycles.
- R11: Control readback returns the stored option bits and the clamped count, with the live busy flag in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe; starts a burst |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rdata_o | output | 8 | Control readback with busy in bit 6 |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Data register write value |
| data_rdata_o | output | 8 | Data register contents |
| sck_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data in from the pad |
| irq_o | output | 1 | One-cycle end-of-burst interrupt |

## Verification
Transmit bursts use several patterns: 0xA5 with a full count, a three-bit partial burst, and an over-range count. Comparing the captured bits at each rising clock catches wrong bit order, wrong count and off-by-one shifting. Receive bursts use a full byte and a four-bit burst over preloaded data, which separates right-justification from plain replacement of the register. Release, zero-count, wait-for-ready and busy-write patterns each cover one end-of-burst path: release timing, line takeover, a held busy versus an ignored option, and rejected writes.

// File: rtl/uw_pkg.sv
package uw_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_END,
    ST_WAIT
  } uw_state_e;
endpackage

// File: rtl/uw_clk_div.sv
module uw_clk_div #(
  parameter int unsigned HALF_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uw_shreg.sv
module uw_shreg
  import uw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          shift_i,
  input  logic          shin_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (load_i)   q_o <= load_data_i;
    else if (shift_i)  q_o <= {q_o[DW-2:0], shin_i};
  end
endmodule

// File: rtl/uw_ctrl.sv
module uw_ctrl
  import uw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] ctrl_wdata_i,
  input  logic          tick_i,
  input  logic          sd_i,
  output logic          run_o,
  output logic          busy_o,
  output logic          sck_o,
  output logic          shift_o,
  output logic          rx_o,
  output logic          released_o,
  output logic          irq_o,
  output logic [DW-1:0] cfg_o
);
  localparam logic [NW-1:0] MAXCNT = NW'(DW);

  uw_state_e     state_q;
  logic          wfr_q, hiz_q, rd_cfg_q, rx_q, rel_q, sd_q, irq_q;
  logic [NW-1:0] cnt_q, left_q, cnt_cl;
  logic          start;

  assign start  = ctrl_we_i && (state_q == ST_IDLE);
  assign cnt_cl = (ctrl_wdata_i[NW-1:0] > MAXCNT) ? MAXCNT : ctrl_wdata_i[NW-1:0];

  assign busy_o     = (state_q != ST_IDLE);
  assign run_o      = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign sck_o      = (state_q == ST_HIGH);
  // receive shifts at the rising edge, transmit at the falling edge
  assign shift_o    = tick_i && (((state_q == ST_LOW) && rx_q) ||
                                 ((state_q == ST_HIGH) && !rx_q));
  assign rx_o       = rx_q;
  assign released_o = rel_q;
  assign irq_o      = irq_q;
  assign cfg_o      = {wfr_q, busy_o, hiz_q, rd_cfg_q, cnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wfr_q    <= 1'b0;
      hiz_q    <= 1'b0;
      rd_cfg_q <= 1'b0;
      rx_q     <= 1'b0;
      rel_q    <= 1'b0;
      cnt_q    <= '0;
      left_q   <= '0;
      sd_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      sd_q  <= sd_i;
      unique case (state_q)
        ST_IDLE: if (start) begin
          wfr_q    <= ctrl_wdata_i[7];
          hiz_q    <= ctrl_wdata_i[5];
          rd_cfg_q <= ctrl_wdata_i[4];
          cnt_q    <= cnt_cl;
          left_q   <= cnt_cl;
          if (cnt_cl == '0) begin
            rx_q    <= 1'b0;
            rel_q   <= ctrl_wdata_i[5];
            state_q <= ST_END;
          end else begin
            rx_q    <= ctrl_wdata_i[4];
            rel_q   <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          if (left_q == NW'(1)) rel_q <= hiz_q;
        end
        ST_HIGH: if (tick_i) begin
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == NW'(1)) ? ST_END : ST_LOW;
        end
        ST_END: begin
          if (wfr_q && hiz_q) state_q <= ST_WAIT;
          else begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b1;
          end
        end
        ST_WAIT: if (sd_i && !sd_q) begin
          state_q <= ST_IDLE;
          irq_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uw_eeprom_shifter.sv
module uw_eeprom_shifter
  import uw_pkg::*;
#(
  parameter int unsigned SYS_HZ = 100_000_000,
  parameter int unsigned SCK_HZ = 500_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] ctrl_wdata_i,
  output logic [DW-1:0] ctrl_rdata_o,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_wdata_i,
  output logic [DW-1:0] data_rdata_o,
  output logic          sck_o,
  output logic          sd_o,
  output logic          sd_oe_o,
  input  logic          sd_i,
  output logic          irq_o
);
  localparam int unsigned HALF_DIV_RAW = SYS_HZ / (2 * SCK_HZ);
  localparam int unsigned HALF_DIV     = (HALF_DIV_RAW < 1) ? 1 : HALF_DIV_RAW;

  logic run, tick, busy, shift, rx, released;

  uw_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .tick_o (tick)
  );

  uw_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .tick_i       (tick),
    .sd_i         (sd_i),
    .run_o        (run),
    .busy_o       (busy),
    .sck_o        (sck_o),
    .shift_o      (shift),
    .rx_o         (rx),
    .released_o   (released),
    .irq_o        (irq_o),
    .cfg_o        (ctrl_rdata_o)
  );

  uw_shreg u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (data_we_i && !busy),
    .load_data_i (data_wdata_i),
    .shift_i     (shift),
    .shin_i      (rx ? sd_i : 1'b0),
    .q_o         (data_rdata_o)
  );

  assign sd_o    = data_rdata_o[DW-1];
  assign sd_oe_o = !rx && !released;
endmodule

// File: rtl/uw_eeprom_shifter_chk.sv
module uw_eeprom_shifter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_rdata_o,
  input logic       sck_o,
  input logic       sd_o,
  input logic       sd_oe_o,
  input logic       irq_o
);
  logic busy;
  assign busy = ctrl_rdata_o[6];

  p_sck_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);

  p_irq_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> irq_o);

  p_irq_only_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $fell(busy));

  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_sd_hold_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(sd_o));

  p_rx_undriven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sck_o && ctrl_rdata_o[4]) |-> !sd_oe_o);

  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(ctrl_rdata_o & 8'hBF));

  p_cnt_clamped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[3:0] <= 4'd8);
endmodule

bind uw_eeprom_shifter uw_eeprom_shifter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_rdata_o (ctrl_rdata_o),
  .sck_o        (sck_o),
  .sd_o         (sd_o),
  .sd_oe_o      (sd_oe_o),
  .irq_o        (irq_o)
);

// File: tb/uw_eeprom_shifter_test.sv
module uw_eeprom_shifter_test;
  localparam int unsigned SYS = 200_000_000;
  localparam int unsigned SCK = 500_000;
  localparam int unsigned PER = 2 * (SYS / (2 * SCK));

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0;
  logic [7:0] ctrl_wd = '0, data_wd = '0;
  logic [7:0] ctrl_rd, data_rd;
  logic sck, sdo, sdoe, irq, sdi;
  logic rd_drv = 1'b0, sd_man = 1'b0, sd_rd = 1'b0;
  logic [7:0] rvec = '0;
  int   rn = 0, rd_base = 0;

  int errors = 0, checks = 0;
  int rises = 0, irqs = 0, cyc = 0, last_rise = 0, period = 0;
  logic [7:0] cap = '0, oecap = '0;
  logic sck_prev = 1'b0;

  assign sdi = rd_drv ? sd_rd : sd_man;

  always #2.5 clk = ~clk;

  uw_eeprom_shifter #(.SYS_HZ(SYS), .SCK_HZ(SCK)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_rdata_o(ctrl_rd),
    .data_we_i(data_we), .data_wdata_i(data_wd), .data_rdata_o(data_rd),
    .sck_o(sck), .sd_o(sdo), .sd_oe_o(sdoe), .sd_i(sdi), .irq_o(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor and receive-data model, sampled between edges
  always @(negedge clk) begin
    sck_prev <= sck;
    if (irq) irqs <= irqs + 1;
    if (sck && !sck_prev) begin
      rises     <= rises + 1;
      cap       <= {cap[6:0], sdo};
      oecap     <= {oecap[6:0], sdoe};
      period    <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (!sck && (rises - rd_base) < rn)
      sd_rd <= rvec[rn - 1 - (rises - rd_base)];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wd = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && ctrl_rd[6]; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!ctrl_rd[6] && !sck && !irq, "R1 idle", {ctrl_rd[6], sck, irq}, 0);
    chk(sdoe == 1'b1, "R1 oe", sdoe, 1);
    chk(ctrl_rd == 8'h00 && data_rd == 8'h00, "R1 regs", {ctrl_rd, data_rd}, 0);
  endtask

  task automatic t_tx(input logic [7:0] d, input int n, input logic [3:0] cfield);
    int r0, i0;
    logic [7:0] m;
    wr_data(d);
    r0 = rises; i0 = irqs;
    wr_ctrl({4'h0, cfield});
    chk(ctrl_rd[6] == 1'b1, "R7 busy set", ctrl_rd[6], 1);
    wait_idle();
    m = (n == 8) ? 8'hFF : 8'((1 << n) - 1);
    chk(rises - r0 == n, "R2 clock count", rises - r0, n);
    chk((cap & m) == ((d >> (8 - n)) & m), "R2 bits msb first", cap & m, (d >> (8 - n)) & m);
    chk((oecap & m) == m, "R5 driven when not released", oecap & m, m);
    chk(irqs - i0 == 1, "R7 single irq", irqs - i0, 1);
    chk(ctrl_rd == {4'h0, 4'(n)}, "R11 readback", ctrl_rd, n);
    chk(!sck, "R10 idle low", sck, 0);
  endtask

  task automatic t_rx(input logic [7:0] pre, input logic [7:0] v, input int n);
    logic [7:0] exp;
    wr_data(pre);
    rvec = v; rn = n; rd_base = rises; rd_drv = 1'b1;
    wr_ctrl(8'h10 | 8'(n));
    repeat (PER) @(negedge clk);
    chk(!sdoe, "R3 not driven", sdoe, 0);
    wait_idle();
    rd_drv = 1'b0;
    exp = (n == 8) ? v : 8'((pre << n) | (v & 8'((1 << n) - 1)));
    chk(data_rd == exp, "R3 right-justified", data_rd, exp);
    chk(rises - rd_base == n, "R3 clock count", rises - rd_base, n);
  endtask

  task automatic t_clamp();
    int r0;
    wr_data(8'h3C);
    r0 = rises;
    wr_ctrl(8'h0C);
    chk(ctrl_rd[3:0] == 4'd8, "R4 clamped readback", ctrl_rd[3:0], 8);
    wait_idle();
    chk(rises - r0 == 8, "R4 clamped clocks", rises - r0, 8);
    chk(cap == 8'h3C, "R4 bits", cap, 8'h3C);
  endtask

  task automatic t_hiz();
    wr_data(8'hFF);
    wr_ctrl(8'h28);
    wait_idle();
    chk(oecap == 8'hFE, "R5 release at last rise", oecap, 8'hFE);
    chk(!sdoe, "R5 released after", sdoe, 0);
  endtask

  task automatic t_zero();
    int r0, i0;
    r0 = rises; i0 = irqs;
    wr_ctrl(8'h30);
    wait_idle();
    chk(!sdoe && rises == r0, "R6 zero count hiz", {sdoe, 8'(rises - r0)}, 0);
    wr_ctrl(8'h10);
    wait_idle();
    chk(sdoe == 1'b1, "R6 take back line", sdoe, 1);
    chk(rises == r0 && irqs - i0 == 2, "R6 no clocks, R7 irqs", irqs - i0, 2);
  endtask

  task automatic t_wfr();
    int i0;
    sd_man = 1'b0;
    wr_data(8'h81);
    i0 = irqs;
    wr_ctrl(8'hA8);
    repeat (9 * PER) @(negedge clk);
    chk(ctrl_rd[6] == 1'b1 && !sck, "R8 held busy", ctrl_rd[6], 1);
    chk(irqs == i0, "R8 no early irq", irqs - i0, 0);
    sd_man = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ctrl_rd[6] && irqs - i0 == 1, "R8 released by ready", irqs - i0, 1);
    sd_man = 1'b0;
    i0 = irqs;
    wr_ctrl(8'h88);
    repeat (9 * PER) @(negedge clk);
    chk(!ctrl_rd[6] && irqs - i0 == 1, "R8 ignored without hiz", ctrl_rd[6], 0);
    chk(period == PER, "R10 clock period", period, PER);
  endtask

  task automatic t_busy_wr();
    int r0;
    wr_data(8'hA5);
    r0 = rises;
    wr_ctrl(8'h08);
    repeat (PER) @(negedge clk);
    wr_ctrl(8'h13);
    wr_data(8'hFF);
    chk(ctrl_rd == 8'h48, "R9 ctrl ignored", ctrl_rd, 8'h48);
    wait_idle();
    chk(rises - r0 == 8 && cap == 8'hA5, "R9 burst intact", cap, 8'hA5);
    chk(data_rd == 8'h00, "R9 data not loaded", data_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx(8'hA5, 8, 4'd8);
    t_tx(8'hC0, 3, 4'd3);
    t_rx(8'h00, 8'h3C, 8);
    t_rx(8'hA5, 8'h0B, 4);
    t_clamp();
    t_hiz();
    t_zero();
    t_wfr();
    t_busy_wr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule